// File: doc/BRIEF.md
# Two-Dimensional Scan Address Generator

This block produces the (x, y) data addresses that carry a scan window across a data map held in memory. Software or a sequencer first places the window with an absolute move. It then loads the clipping window: a lower and an upper bound for each axis. Last, it starts a scan pattern made of a signed step for each axis, a step count and a direction flag. From then on the generator needs no further control. It adds the step to the current location and offers each new location on a valid/ready output. The location advances only when the consumer accepts an address.

A scan ends in one of two ways. When the count runs out, a one-cycle done pulse is raised. When a candidate location falls outside the clipping window, a one-cycle escape pulse is raised instead and that location is never offered. In reverse mode the same set of locations comes out in the opposite order. The generator starts at the far end of the forward path and walks back with the negated step.

Top module: `scan_addr_gen`

## Requirements
- R1: After reset `busy`, `addr_valid`, `done` and `escape` are 0. The location is (0,0) and both axes have the bounds 0..255.
- R2: While idle, `mov_en` sets the location to (`mov_x`,`mov_y`). A move requested in the same cycle as `go_en` has no effect.
- R3: In forward mode (`go_rev`=0) a scan from location P with step d (8-bit two's complement per axis) and count n presents P+k·d for k=1..n, in that order. Each coordinate is 8-bit unsigned.
- R4: A presented address stays on `addr_x`/`addr_y` with `addr_valid` high until `addr_ready` is high on a clock edge. The location advances only on such a handshake.
- R5: After the n-th handshake, `done` is high for exactly one cycle, in the cycle after that handshake, and `busy` is low in that cycle. A start with count 0 presents no address and raises `done` in the cycle after the start.
- R6: Bounds are inclusive, and each axis has its own bounds. When a candidate lies outside the bounds, whether below or above, it is not presented. `escape` then pulses for one cycle, one cycle after the candidate was formed, and `busy` falls. The location stays at the last accepted address. There is no modular wrap.
- R7: When the n-th candidate is out of bounds, the scan ends with `escape` and `done` stays low. The two pulses are never high together.
- R8: In reverse mode (`go_rev`=1) the scan presents P+n·d, P+(n−1)·d, …, P+d. After completion the location is P+d.
- R9: While `busy` is high, `mov_en`, `lim_en` and `go_en` have no effect on the current scan, the location or the bounds.
- R10: With `addr_ready` held high, a forward or reverse scan of n in-bounds steps presents one address per cycle. `done` follows n cycles after the start edge.
- R11: Bounds loaded with `lim_en` in the same cycle as a start apply to that scan. After a scan, the location it reached is the start point of the next scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mov_en | input | 1 | Absolute move request |
| mov_x | input | 8 | Move target x |
| mov_y | input | 8 | Move target y |
| lim_en | input | 1 | Load clipping bounds |
| lim_x_lo | input | 8 | Lowest allowed x |
| lim_x_hi | input | 8 | Highest allowed x |
| lim_y_lo | input | 8 | Lowest allowed y |
| lim_y_hi | input | 8 | Highest allowed y |
| go_en | input | 1 | Start a scan pattern |
| go_dx | input | 8 | Signed x step |
| go_dy | input | 8 | Signed y step |
| go_cnt | input | 8 | Number of steps |
| go_rev | input | 1 | 1 = reverse order |
| addr_ready | input | 1 | Consumer accepts the address |
| addr_valid | output | 1 | Address is presented |
| addr_x | output | 8 | Presented x |
| addr_y | output | 8 | Presented y |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Count exhausted (pulse) |
| escape | output | 1 | Off-limits end (pulse) |

## Verification
Exhaustion of the count and a bounds violation can fall on the same step. This happens when the n-th candidate is the first one outside the bounds. The bench provokes it by choosing a step that crosses the upper x bound on exactly the last step. It then requires an escape pulse, no done pulse and no presented address for that step. Across a sweep of steps, counts, directions and consumer stall patterns, every end is judged against an arithmetic model. That model marks the first out-of-bounds step, so both the coincident case and the early-escape case are compared cycle by cycle.

// File: rtl/scan_pkg.sv
// Shared types and width helpers for the scan address generator.
// Assumes: coordinate, step and count widths are each at least 2.
package scan_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } scan_state_e;

    // Signed width that holds location + count * step without overflow.
    function automatic int pos_width(input int cw, input int sw, input int nw);
        return ((nw + sw > cw) ? nw + sw : cw) + 2;
    endfunction

endpackage

// File: rtl/scan_axis.sv
// One axis of the scan generator: the location, the clipping bounds, the
// next-candidate register and its bounds comparators.
// Assumes: mov_ok, start_ok and advance are mutually exclusive (the
// controller only grants a move or a start while idle).
module scan_axis
    import scan_pkg::*;
#(
    parameter int CW = 8,
    parameter int SW = 8,
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mov_ok,
    input  logic [CW-1:0] mov_val,
    input  logic          lim_ok,
    input  logic [CW-1:0] lim_lo,
    input  logic [CW-1:0] lim_hi,
    input  logic          start_ok,
    input  logic [SW-1:0] step_val,
    input  logic [NW-1:0] step_cnt,
    input  logic          rev,
    input  logic          advance,
    output logic [CW-1:0] cand_val,
    output logic          off_lim
);
    localparam int PW = pos_width(CW, SW, NW);

    logic [CW-1:0]        cur_q, lo_q, hi_q;
    logic signed [PW-1:0] cand_q, inc_q;
    logic signed [PW-1:0] cur_w, step_w, cnt_w, first_w, lo_w, hi_w;

    // Widen operands to signed position width.
    always_comb begin
        cur_w   = $signed({{(PW-CW){1'b0}}, cur_q});
        step_w  = $signed({{(PW-SW){step_val[SW-1]}}, step_val});
        cnt_w   = $signed({{(PW-NW){1'b0}}, step_cnt});
        first_w = rev ? (cur_w + cnt_w * step_w) : (cur_w + step_w);
        lo_w    = $signed({{(PW-CW){1'b0}}, lo_q});
        hi_w    = $signed({{(PW-CW){1'b0}}, hi_q});
    end

    // Bounds comparators on the pending candidate.
    assign off_lim  = (cand_q < lo_w) || (cand_q > hi_w);
    assign cand_val = cand_q[CW-1:0];

    // Location register: absolute move or accepted address.
    always_ff @(posedge clk) begin
        if (!rst_n)       cur_q <= '0;
        else if (mov_ok)  cur_q <= mov_val;
        else if (advance) cur_q <= cand_q[CW-1:0];
    end

    // Clipping bounds registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '1;
        end else if (lim_ok) begin
            lo_q <= lim_lo;
            hi_q <= lim_hi;
        end
    end

    // Candidate and signed increment: seeded at start, stepped on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q <= '0;
            inc_q  <= '0;
        end else if (start_ok) begin
            cand_q <= first_w;
            inc_q  <= rev ? -step_w : step_w;
        end else if (advance) begin
            cand_q <= cand_q + inc_q;
        end
    end

    // R6
    no_off_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> !off_lim);

endmodule

// File: rtl/scan_ctrl.sv
// Scan controller: grants commands while idle, counts steps, and ends the
// scan with a done or escape pulse.
// Assumes: off_any reflects the candidate of the current cycle.
module scan_ctrl
    import scan_pkg::*;
#(
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mov_en,
    input  logic          lim_en,
    input  logic          go_en,
    input  logic [NW-1:0] go_cnt,
    input  logic          off_any,
    input  logic          addr_ready,
    output logic          mov_ok,
    output logic          lim_ok,
    output logic          start_ok,
    output logic          addr_valid,
    output logic          advance,
    output logic          busy,
    output logic          done,
    output logic          escape
);
    scan_state_e   state_q;
    logic [NW-1:0] rem_q;
    logic          done_q, esc_q, idle, cnt_zero;

    // Command grants and handshake.
    always_comb begin
        idle       = (state_q == ST_IDLE);
        cnt_zero   = (go_cnt == '0);
        start_ok   = go_en && idle && !cnt_zero;
        mov_ok     = mov_en && idle && !go_en;
        lim_ok     = lim_en && idle;
        addr_valid = (state_q == ST_RUN) && !off_any;
        advance    = addr_valid && addr_ready;
    end

    assign busy   = (state_q == ST_RUN);
    assign done   = done_q;
    assign escape = esc_q;

    // State, remaining count and end pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
            done_q  <= 1'b0;
            esc_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            esc_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (go_en) begin
                        if (cnt_zero) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= ST_RUN;
                            rem_q   <= go_cnt;
                        end
                    end
                end
                default: begin
                    if (off_any) begin
                        esc_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (advance) begin
                        rem_q <= rem_q - 1'b1;
                        if (rem_q == NW'(1)) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    // R7
    one_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_q && esc_q));

    // R6
    esc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        esc_q |-> $past(busy && !addr_valid));

    // R5
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ($past(advance) || $past(go_en && idle && cnt_zero)));

    // R9
    busy_go_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go_en && !advance && !off_any) |=> (busy && rem_q == $past(rem_q)));

endmodule

// File: rtl/scan_addr_gen.sv
// Two-dimensional scan address generator top: one axis slice per dimension
// and a shared controller. Produces location + step per accepted handshake,
// ending on count exhaustion or on an out-of-bounds candidate.
// Assumes: the consumer obeys valid/ready; commands are single-cycle strobes.
module scan_addr_gen
    import scan_pkg::*;
#(
    parameter int CW = 8,
    parameter int SW = 8,
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mov_en,
    input  logic [CW-1:0] mov_x,
    input  logic [CW-1:0] mov_y,
    input  logic          lim_en,
    input  logic [CW-1:0] lim_x_lo,
    input  logic [CW-1:0] lim_x_hi,
    input  logic [CW-1:0] lim_y_lo,
    input  logic [CW-1:0] lim_y_hi,
    input  logic          go_en,
    input  logic [SW-1:0] go_dx,
    input  logic [SW-1:0] go_dy,
    input  logic [NW-1:0] go_cnt,
    input  logic          go_rev,
    input  logic          addr_ready,
    output logic          addr_valid,
    output logic [CW-1:0] addr_x,
    output logic [CW-1:0] addr_y,
    output logic          busy,
    output logic          done,
    output logic          escape
);
    localparam int AXES = 2;

    logic [AXES-1:0][CW-1:0] mov_a, lo_a, hi_a, cand_a;
    logic [AXES-1:0][SW-1:0] step_a;
    logic [AXES-1:0]         off_a;
    logic                    mov_ok, lim_ok, start_ok, advance;

    // Pack per-axis operands (index 0 = x, 1 = y).
    assign mov_a  = {mov_y, mov_x};
    assign lo_a   = {lim_y_lo, lim_x_lo};
    assign hi_a   = {lim_y_hi, lim_x_hi};
    assign step_a = {go_dy, go_dx};
    assign addr_x = cand_a[0];
    assign addr_y = cand_a[1];

    for (genvar g = 0; g < AXES; g++) begin : g_axis
        scan_axis #(.CW(CW), .SW(SW), .NW(NW)) u_axis (
            .clk      (clk),
            .rst_n    (rst_n),
            .mov_ok   (mov_ok),
            .mov_val  (mov_a[g]),
            .lim_ok   (lim_ok),
            .lim_lo   (lo_a[g]),
            .lim_hi   (hi_a[g]),
            .start_ok (start_ok),
            .step_val (step_a[g]),
            .step_cnt (go_cnt),
            .rev      (go_rev),
            .advance  (advance),
            .cand_val (cand_a[g]),
            .off_lim  (off_a[g])
        );
    end

    scan_ctrl #(.NW(NW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mov_en     (mov_en),
        .lim_en     (lim_en),
        .go_en      (go_en),
        .go_cnt     (go_cnt),
        .off_any    (|off_a),
        .addr_ready (addr_ready),
        .mov_ok     (mov_ok),
        .lim_ok     (lim_ok),
        .start_ok   (start_ok),
        .addr_valid (addr_valid),
        .advance    (advance),
        .busy       (busy),
        .done       (done),
        .escape     (escape)
    );

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr_x) && $stable(addr_y)));

endmodule

// File: tb/test_scan_addr_gen.sv
`timescale 1ns/1ps
module test_scan_addr_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mov_en = 0, lim_en = 0, go_en = 0, go_rev = 0, addr_ready = 0;
    logic [7:0] mov_x = 0, mov_y = 0, lim_x_lo = 0, lim_x_hi = 0, lim_y_lo = 0, lim_y_hi = 0;
    logic [7:0] go_dx = 0, go_dy = 0, go_cnt = 0;
    logic       addr_valid, busy, done, escape;
    logic [7:0] addr_x, addr_y;

    int n_chk = 0, n_bad = 0;
    int loc_x = 0, loc_y = 0, lxl = 0, lxh = 255, lyl = 0, lyh = 255;

    always #4 clk = ~clk;

    scan_addr_gen i_scan_addr_gen (
        .clk(clk), .rst_n(rst_n),
        .mov_en(mov_en), .mov_x(mov_x), .mov_y(mov_y),
        .lim_en(lim_en), .lim_x_lo(lim_x_lo), .lim_x_hi(lim_x_hi),
        .lim_y_lo(lim_y_lo), .lim_y_hi(lim_y_hi),
        .go_en(go_en), .go_dx(go_dx), .go_dy(go_dy), .go_cnt(go_cnt), .go_rev(go_rev),
        .addr_ready(addr_ready), .addr_valid(addr_valid), .addr_x(addr_x), .addr_y(addr_y),
        .busy(busy), .done(done), .escape(escape)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_move(input int x, input int y);
        @(negedge clk);
        mov_en = 1; mov_x = 8'(x); mov_y = 8'(y);
        @(negedge clk);
        mov_en = 0;
        loc_x = x; loc_y = y;
    endtask

    task automatic do_limits(input int xl, input int xh, input int yl, input int yh);
        @(negedge clk);
        lim_en = 1; lim_x_lo = 8'(xl); lim_x_hi = 8'(xh); lim_y_lo = 8'(yl); lim_y_hi = 8'(yh);
        @(negedge clk);
        lim_en = 0;
        lxl = xl; lxh = xh; lyl = yl; lyh = yh;
    endtask

    // rmode: 0 ready always, 1 alternate, 2 pseudo-random stalls.
    // inject: pulse move/limits/start while busy. mvgo: move together with start.
    task automatic run_scan(input int dx, input int dy, input int n, input bit rev,
                            input int rmode, input bit inject, input bit mvgo);
        int ex[256];
        int ey[256];
        int n_emit = n;
        bit esc = 0;
        int e = 0;
        int k = 0;
        string rq = rev ? "R8" : "R3";
        for (int s = 1; s <= n; s++) begin
            int m = rev ? (n + 1 - s) : s;
            int px = loc_x + m * dx;
            int py = loc_y + m * dy;
            if (px < lxl || px > lxh || py < lyl || py > lyh) begin
                esc = 1; n_emit = s - 1; break;
            end
            ex[s-1] = px; ey[s-1] = py;
        end
        @(negedge clk);
        go_en = 1; go_dx = 8'(dx); go_dy = 8'(dy); go_cnt = 8'(n); go_rev = rev;
        if (mvgo) begin mov_en = 1; mov_x = 8'd7; mov_y = 8'd9; end
        @(negedge clk);
        go_en = 0; mov_en = 0;
        forever begin
            if (e == n_emit) begin
                if (!esc) begin
                    chk(done == 1'b1, "R5", "done at end", int'(done), 1);
                    chk(busy == 1'b0 && addr_valid == 1'b0, "R5", "idle at done", int'(busy), 0);
                    chk(escape == 1'b0, "R7", "no escape at done", int'(escape), 0);
                    if (rmode == 0) chk(k == n, "R10", "cycles to done", k, n);
                end else begin
                    chk(addr_valid == 1'b0 && escape == 1'b0, "R6", "offending addr hidden",
                        int'(addr_valid), 0);
                    @(negedge clk);
                    chk(escape == 1'b1 && busy == 1'b0, (n_emit == n - 1) ? "R7" : "R6",
                        "escape pulse", int'(escape), 1);
                    chk(done == 1'b0, "R7", "no done on escape", int'(done), 0);
                end
                break;
            end
            chk(addr_valid == 1'b1 && busy == 1'b1 && done == 1'b0, rq, "valid while running",
                int'(addr_valid), 1);
            chk(int'(addr_x) == ex[e], rq, "addr_x", int'(addr_x), ex[e]);
            chk(int'(addr_y) == ey[e], rq, "addr_y", int'(addr_y), ey[e]);
            if (inject && e == 0) begin
                mov_en = 1; mov_x = 8'd200; mov_y = 8'd200;
                lim_en = 1; lim_x_lo = 8'd0; lim_x_hi = 8'd0; lim_y_lo = 8'd0; lim_y_hi = 8'd0;
                go_en = 1; go_cnt = 8'd1; go_dx = 8'd3;
            end
            case (rmode)
                0: addr_ready = 1;
                1: addr_ready = (k % 2) == 1;
                default: addr_ready = ((k * 5 + e) % 3) != 0;
            endcase
            if (addr_ready) e++;
            k++;
            @(negedge clk);
            mov_en = 0; lim_en = 0; go_en = 0;
            if (k > 600) begin chk(0, rq, "scan hung", k, n); break; end
        end
        addr_ready = 0;
        @(negedge clk);
        chk(done == 1'b0 && escape == 1'b0, "R5", "end pulse one cycle", int'(done | escape), 0);
        if (n_emit > 0) begin loc_x = ex[n_emit-1]; loc_y = ey[n_emit-1]; end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int dv[5] = '{-3, -1, 0, 2, 5};
        int nv[4] = '{0, 1, 4, 7};
        int idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state, location (0,0), full bounds
        chk(!busy && !addr_valid && !done && !escape, "R1", "reset outputs", int'(busy), 0);
        run_scan(-1, 0, 1, 0, 0, 0, 0);      // R1 lower bound 0: immediate escape
        run_scan(1, 2, 2, 0, 0, 0, 0);       // R1 start at (0,0)
        run_scan(1, 1, 2, 0, 1, 0, 0);       // R11 chained from reached location
        // R2/R9 sweep with bounded window
        for (int a = 0; a < 5; a++) begin
            for (int b = 0; b < 5; b++) begin
                for (int c = 0; c < 4; c++) begin
                    for (int r = 0; r < 2; r++) begin
                        do_limits(90, 120, 80, 130);
                        do_move(100 + a, 105 - b);
                        run_scan(dv[a], dv[b], nv[c], r[0], idx % 3, 0, 0);
                        idx++;
                    end
                end
            end
        end
        // R6: no wrap at top of range
        do_limits(0, 255, 0, 255);
        do_move(250, 3);
        run_scan(5, 0, 3, 0, 2, 0, 0);
        // R8/R10: long reverse scan
        do_move(10, 10);
        run_scan(1, 0, 200, 1, 0, 0, 0);
        // R6: reverse far end out of range
        do_move(0, 0);
        run_scan(-128, 0, 255, 1, 0, 0, 0);
        // R7: last step crosses upper x bound
        do_limits(0, 108, 0, 255);
        do_move(100, 100);
        run_scan(5, 0, 2, 0, 1, 0, 0);
        // R9: commands while busy ignored, confirmed by follow-up scan
        do_limits(0, 255, 0, 255);
        do_move(50, 50);
        run_scan(2, 1, 5, 0, 2, 1, 0);
        run_scan(1, 0, 1, 0, 0, 0, 0);
        // R2: move in the start cycle ignored (count 0 start)
        run_scan(0, 0, 0, 0, 0, 0, 1);
        run_scan(0, 1, 1, 0, 0, 0, 0);
        // R11: bounds loaded in the same cycle as the start apply
        do_move(20, 20);
        @(negedge clk);
        lim_en = 1; lim_x_lo = 8'd0; lim_x_hi = 8'd21; lim_y_lo = 8'd0; lim_y_hi = 8'd255;
        go_en = 1; go_dx = 8'd1; go_dy = 8'd0; go_cnt = 8'd3; go_rev = 0; addr_ready = 1;
        @(negedge clk);
        lim_en = 0; go_en = 0;
        chk(addr_valid && addr_x == 8'd21, "R11", "first addr in new bounds", int'(addr_x), 21);
        @(negedge clk);
        chk(!addr_valid && busy, "R11", "second addr blocked", int'(addr_valid), 0);
        @(negedge clk);
        chk(escape == 1'b1, "R11", "escape from new bound", int'(escape), 1);
        addr_ready = 0;
        @(negedge clk);
        finish_run();
    end
endmodule